// File: doc/BRIEF.md
# Differential Escalation Link

This block carries one escalation level from a sending side to a receiving side over a complementary wire pair. A second complementary pair carries a response back. The sending side takes an escalation request and a liveness (ping) request. It reports ping completion and integrity failures. The receiving side raises the escalation-active output and drives the response. Pings and escalations share the forward pair and are told apart only by how long the positive wire stays high. A ping is a single high cycle. An escalation holds the wire high for two or more cycles.

Each side follows the same rule for the response, so the sender always knows the value it should see. After any cycle in which the forward pair carries a valid high, the response bit flips. After any other cycle it returns to low. A ping therefore comes back as one high cycle followed by one low cycle. During an escalation the response toggles every cycle. The sender compares every cycle against its own copy of this rule. Three conditions count as an integrity failure: a non-complementary response pair, a response value that differs from the expected one, and any response activity while the link should be quiet. When the receiver sees a non-complementary forward pair, it drives both response wires to the same level for one cycle, so the fault reaches the sender one cycle later.

The top module holds both sides and the four wires between them. It has one fault-injection input per wire, which inverts that wire in flight. In normal use these inputs are tied low.

Sender states: `TX_IDLE` (quiet; sends a ping pulse when a ping is pending), `TX_PING` (pulse sent, high response expected), `TX_REPLY` (low response expected; ping completes here), `TX_ESC` (escalation in progress). Sender transitions:
- An escalation request moves any state to `TX_ESC`.
- A pending ping moves `TX_IDLE` to `TX_PING`.
- A correct response moves `TX_PING` to `TX_REPLY`; a wrong response moves it back to `TX_IDLE`.
- `TX_REPLY` always moves to `TX_IDLE`.
- `TX_ESC` moves to `TX_IDLE` when the request drops.

Receiver states: `RX_IDLE`, `RX_FIRST` (one high cycle seen), `RX_HELD` (two or more high cycles seen). Receiver transitions:
- A valid high moves `RX_IDLE` to `RX_FIRST`, and `RX_FIRST` or `RX_HELD` to `RX_HELD`.
- A low or an invalid pair moves any state to `RX_IDLE`.

Top module: `esc_link`

## Requirements
- R1: During reset and in the cycles after its release, both wire pairs rest at positive 0 / negative 1. No output is asserted, and no integrity failure is reported.
- R2: When the escalation request rises from idle and is held, `esc_act_o` rises exactly one cycle later. It falls in the same cycle that the request falls.
- R3: An escalation request held for only one cycle is indistinguishable from a ping. It never raises `esc_act_o` and causes no integrity failure.
- R4: A ping requested while idle with no escalation gives `ping_ok_o` high for exactly one cycle, two cycles after `ping_req_i` rises. It does not repeat while the request stays high.
- R5: A ping requested during an escalation gets no `ping_ok_o` while the escalation lasts. It completes three cycles after the escalation request falls.
- R6: An escalation that starts in the cycle after a ping pulse raises `esc_act_o` in that same cycle. The interrupted ping completes three cycles after the escalation ends. No integrity failure is reported.
- R7: While escalation is active, the response positive wire toggles every cycle, and an escalation of any length shows no integrity failure.
- R8: Inverting one response wire in any cycle raises `integ_fail_o` in that same cycle, whether the link is idle, pinging or escalating. Inverting both response wires while idle, which gives a valid-looking high, is also a failure.
- R9: Inverting one forward wire for one idle cycle leaves `integ_fail_o` low in that cycle and raises it in the next cycle only. `esc_act_o` stays low.
- R10: A ping whose response is corrupted in cycle d after the request rises (d = 0, 1, 2) is retried. `ping_ok_o` comes 2 cycles after the rise for d = 0 and 3 + d cycles after it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| esc_req_i | input | 1 | Escalation request level |
| ping_req_i | input | 1 | Ping request; held until `ping_ok_o` is seen |
| flt_esc_p_i | input | 1 | Inverts the forward positive wire |
| flt_esc_n_i | input | 1 | Inverts the forward negative wire |
| flt_resp_p_i | input | 1 | Inverts the response positive wire |
| flt_resp_n_i | input | 1 | Inverts the response negative wire |
| ping_ok_o | output | 1 | One-cycle ping completion |
| integ_fail_o | output | 1 | Integrity failure on the link |
| esc_act_o | output | 1 | Escalation active at the receiving side |

## Verification
The bench sweeps escalation lengths from one to six cycles. A receiver that treated the first high cycle as escalation would fire on every ping, and one that waited too long would miss the one-cycle rise latency. It injects every single-wire fault on the response pair in each phase (idle, ping pulse, ping reply, escalation). It also injects single-wire faults on the forward pair while idle. A sender with a wrong expected phase would report spurious failures during long escalations, and a receiver that did not forward faults would leave forward faults unreported. Pings that collide with escalation on either side, and corrupted pings, are checked for exact completion cycles. This catches a sender that drops a pending ping or completes one without a correct response.

// File: rtl/esc_link_pkg.sv
package esc_link_pkg;

    typedef struct packed {
        logic p;
        logic n;
    } diff_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_PING,
        TX_REPLY,
        TX_ESC
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_FIRST,
        RX_HELD
    } rx_state_e;

    function automatic logic diff_ok(diff_t d);
        return d.p ^ d.n;
    endfunction

endpackage

// File: rtl/esc_tx.sv
module esc_tx
    import esc_link_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  esc_req_i,
    input  logic  ping_req_i,
    input  diff_t resp_i,
    output diff_t esc_o,
    output logic  ping_ok_o,
    output logic  integ_fail_o
);

    tx_state_e state_q, state_d;
    logic      exp_q;
    logic      served_q;
    logic      pend;
    logic      send;
    logic      resp_good;

    always_comb begin
        pend      = ping_req_i && !served_q;
        send      = esc_req_i || ((state_q == TX_IDLE) && pend);
        resp_good = diff_ok(resp_i) && (resp_i.p == exp_q);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (esc_req_i)  state_d = TX_ESC;
                else if (pend)  state_d = TX_PING;
            end
            TX_PING: begin
                if (esc_req_i)      state_d = TX_ESC;
                else if (resp_good) state_d = TX_REPLY;
                else                state_d = TX_IDLE;
            end
            TX_REPLY: begin
                state_d = esc_req_i ? TX_ESC : TX_IDLE;
            end
            TX_ESC: begin
                state_d = esc_req_i ? TX_ESC : TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q  <= TX_IDLE;
            exp_q    <= 1'b0;
            served_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            exp_q    <= send ? ~exp_q : 1'b0;
            served_q <= ping_req_i && (served_q || ping_ok_o);
        end
    end

    always_comb begin
        esc_o.p      = rst_ni && send;
        esc_o.n      = !(rst_ni && send);
        ping_ok_o    = (state_q == TX_REPLY) && resp_good;
        integ_fail_o = !resp_good;
    end

    a_r4_ok_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ping_ok_o |-> ping_req_i);

    a_r4_ok_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ping_ok_o |=> !ping_ok_o);

endmodule

// File: rtl/esc_rx.sv
module esc_rx
    import esc_link_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  diff_t esc_i,
    output diff_t resp_o,
    output logic  esc_act_o
);

    rx_state_e state_q, state_d;
    logic      tog_q;
    logic      err_q;
    logic      hi;
    logic      bad;

    always_comb begin
        bad = !diff_ok(esc_i);
        hi  = !bad && esc_i.p;
    end

    always_comb begin
        state_d = RX_IDLE;
        unique case (state_q)
            RX_IDLE:  state_d = hi ? RX_FIRST : RX_IDLE;
            RX_FIRST: state_d = hi ? RX_HELD  : RX_IDLE;
            RX_HELD:  state_d = hi ? RX_HELD  : RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RX_IDLE;
            tog_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            tog_q   <= hi ? ~tog_q : 1'b0;
            err_q   <= bad;
        end
    end

    always_comb begin
        resp_o.p  = tog_q;
        resp_o.n  = ~tog_q ^ err_q;
        esc_act_o = hi && (state_q != RX_IDLE);
    end

    a_r3_first_high_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == RX_IDLE) |-> !esc_act_o);

endmodule

// File: rtl/esc_link.sv
module esc_link
    import esc_link_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic esc_req_i,
    input  logic ping_req_i,
    input  logic flt_esc_p_i,
    input  logic flt_esc_n_i,
    input  logic flt_resp_p_i,
    input  logic flt_resp_n_i,
    output logic ping_ok_o,
    output logic integ_fail_o,
    output logic esc_act_o
);

    diff_t tx_esc, rx_esc;
    diff_t rx_resp, tx_resp;

    // wires between the two sides, each with its fault inverter
    always_comb begin
        rx_esc.p  = tx_esc.p  ^ flt_esc_p_i;
        rx_esc.n  = tx_esc.n  ^ flt_esc_n_i;
        tx_resp.p = rx_resp.p ^ flt_resp_p_i;
        tx_resp.n = rx_resp.n ^ flt_resp_n_i;
    end

    esc_tx u_tx (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .esc_req_i    (esc_req_i),
        .ping_req_i   (ping_req_i),
        .resp_i       (tx_resp),
        .esc_o        (tx_esc),
        .ping_ok_o    (ping_ok_o),
        .integ_fail_o (integ_fail_o)
    );

    esc_rx u_rx (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .esc_i     (rx_esc),
        .resp_o    (rx_resp),
        .esc_act_o (esc_act_o)
    );

    // checker state for the link-level properties
    logic chk_req_q;
    logic chk_clean_q;
    logic esc_clean;

    assign esc_clean = !flt_esc_p_i && !flt_esc_n_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chk_req_q   <= 1'b0;
            chk_clean_q <= 1'b0;
        end else begin
            chk_req_q   <= esc_req_i;
            chk_clean_q <= esc_clean;
        end
    end

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            a_r1_reset_levels: assert (!tx_esc.p && tx_esc.n && !rx_resp.p && rx_resp.n);
        end
    end

    a_r2_act_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_req_q && chk_clean_q && esc_req_i && esc_clean |-> esc_act_o);

    a_r2_act_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        esc_act_o && esc_clean && chk_clean_q |-> esc_req_i);

    a_r7_resp_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
        esc_act_o |=> (rx_resp.p != $past(rx_resp.p)));

    a_r8_resp_fault_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flt_resp_p_i ^ flt_resp_n_i) |-> integ_fail_o);

    a_r9_esc_fault_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !diff_ok(rx_esc) |=> integ_fail_o || (flt_resp_p_i ^ flt_resp_n_i));

endmodule

// File: tb/esc_link_tb.sv
`timescale 1ns/1ps
module esc_link_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic esc_req = 1'b0;
    logic ping_req = 1'b0;
    logic [3:0] flt = 4'b0;  // [0] esc p, [1] esc n, [2] resp p, [3] resp n
    logic ping_ok, integ_fail, esc_act;
    logic s_ok, s_fail, s_act;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    esc_link u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .esc_req_i    (esc_req),
        .ping_req_i   (ping_req),
        .flt_esc_p_i  (flt[0]),
        .flt_esc_n_i  (flt[1]),
        .flt_resp_p_i (flt[2]),
        .flt_resp_n_i (flt[3]),
        .ping_ok_o    (ping_ok),
        .integ_fail_o (integ_fail),
        .esc_act_o    (esc_act)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step(input logic e, input logic p, input logic [3:0] f);
        @(negedge clk);
        esc_req = e;
        ping_req = p;
        flt = f;
        #1;
        s_ok = ping_ok;
        s_fail = integ_fail;
        s_act = esc_act;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b0, 4'b0);
            chk("R1", "quiet fail", s_fail, 1'b0);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) begin
            @(negedge clk);
            #1;
            chk("R1", "fail in reset", integ_fail, 1'b0);
            chk("R1", "act in reset", esc_act, 1'b0);
            chk("R1", "ok in reset", ping_ok, 1'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0, 4'b0);
            chk("R1", "act after reset", s_act, 1'b0);
            chk("R1", "ok after reset", s_ok, 1'b0);
            chk("R1", "fail after reset", s_fail, 1'b0);
        end

        // R2 / R7 escalation length sweep
        for (int k = 2; k <= 6; k++) begin
            idle(2);
            for (int i = 0; i < k; i++) begin
                step(1'b1, 1'b0, 4'b0);
                chk("R2", "act during esc", s_act, (i > 0));
                chk("R7", "fail during esc", s_fail, 1'b0);
            end
            step(1'b0, 1'b0, 4'b0);
            chk("R2", "act at drop", s_act, 1'b0);
            chk("R7", "fail at drop", s_fail, 1'b0);
        end

        // R3 one-cycle escalation request
        idle(2);
        step(1'b1, 1'b0, 4'b0);
        chk("R3", "act pulse c0", s_act, 1'b0);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0, 4'b0);
            chk("R3", "act after pulse", s_act, 1'b0);
            chk("R3", "fail after pulse", s_fail, 1'b0);
        end

        // R4 ping from idle
        idle(2);
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b1, 4'b0);
            chk("R4", "ok timing", s_ok, (i == 2));
            chk("R4", "fail during ping", s_fail, 1'b0);
        end
        step(1'b0, 1'b0, 4'b0);
        chk("R4", "ok after release", s_ok, 1'b0);

        // R5 ping during escalation
        idle(2);
        step(1'b1, 1'b0, 4'b0);
        step(1'b1, 1'b0, 4'b0);
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b1, 4'b0);
            chk("R5", "no ok during esc", s_ok, 1'b0);
            chk("R5", "act during esc", s_act, 1'b1);
        end
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b1, 4'b0);
            chk("R5", "deferred ok", s_ok, (i == 3));
            chk("R5", "fail", s_fail, 1'b0);
        end
        step(1'b0, 1'b0, 4'b0);

        // R6 escalation right after a ping pulse
        idle(2);
        step(1'b0, 1'b1, 4'b0);
        chk("R6", "ok at pulse", s_ok, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b1, 4'b0);
            chk("R6", "act", s_act, 1'b1);
            chk("R6", "fail", s_fail, 1'b0);
            chk("R6", "ok during esc", s_ok, 1'b0);
        end
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b1, 4'b0);
            chk("R6", "ok after esc", s_ok, (i == 3));
            chk("R6", "fail after esc", s_fail, 1'b0);
        end
        step(1'b0, 1'b0, 4'b0);

        // R8 response faults: idle sweep
        idle(2);
        for (int c = 1; c <= 3; c++) begin
            step(1'b0, 1'b0, 4'(c << 2));
            chk("R8", "idle resp fault", s_fail, 1'b1);
            step(1'b0, 1'b0, 4'b0);
            chk("R8", "recover", s_fail, 1'b0);
        end
        // R8 during escalation
        step(1'b1, 1'b0, 4'b0);
        step(1'b1, 1'b0, 4'b0);
        step(1'b1, 1'b0, 4'b1000);
        chk("R8", "esc resp n fault", s_fail, 1'b1);
        step(1'b1, 1'b0, 4'b0100);
        chk("R8", "esc resp p fault", s_fail, 1'b1);
        step(1'b1, 1'b0, 4'b0);
        chk("R8", "esc recover", s_fail, 1'b0);
        chk("R8", "esc still act", s_act, 1'b1);
        step(1'b0, 1'b0, 4'b0);
        chk("R8", "act dropped", s_act, 1'b0);
        chk("R8", "fail after", s_fail, 1'b0);

        // R9 forward wire faults while idle
        for (int c = 1; c <= 2; c++) begin
            idle(2);
            step(1'b0, 1'b0, 4'(c));
            chk("R9", "fail same cycle", s_fail, 1'b0);
            chk("R9", "act at fault", s_act, 1'b0);
            step(1'b0, 1'b0, 4'b0);
            chk("R9", "fail next cycle", s_fail, 1'b1);
            chk("R9", "act next", s_act, 1'b0);
            step(1'b0, 1'b0, 4'b0);
            chk("R9", "fail cleared", s_fail, 1'b0);
        end

        // R10 corrupted ping responses
        for (int d = 0; d <= 2; d++) begin
            for (int w = 0; w < 2; w++) begin
                int exp_i;
                exp_i = (d == 0) ? 2 : 3 + d;
                idle(2);
                for (int i = 0; i < 8; i++) begin
                    step(1'b0, 1'b1, (i == d) ? 4'(4 << w) : 4'b0);
                    chk("R10", "retry ok timing", s_ok, (i == exp_i));
                    if (i == d) chk("R10", "fault flagged", s_fail, 1'b1);
                end
                step(1'b0, 1'b0, 4'b0);
            end
        end

        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule